// File: doc/BRIEF.md
# BCD Calendar Counter with Staged Update

This block holds the time of day and the calendar date as packed BCD fields and advances them by one second on every cycle in which the one-second tick input is high. The fields are seconds, minutes, hours, a weekday index, day of month, month and a two-digit year. Carries pass from the seconds field to the year field. Month lengths follow the calendar, and February takes its length from a leap flag that software stores next to the year.

Software writes a new time through a simple word-wide register port. The writes go into staging copies and do not disturb the running clock. A write that sets the top bit of the trigger register copies every staged field into the live counters in the same clock cycle. A control bit chooses between a 24-hour hour range and a 12-hour range without AM/PM marking.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the live time is 00:00:00, with weekday 0, day 01, month 01, year 00 and the leap flag clear. The control bit is 0, so the block starts in 12-hour range.
- R2: The register addresses are 0 for seconds, 1 for minutes, 2 for hours, 3 for weekday, 4 for day, 5 for month, 6 for year (leap flag in bit 15), 7 for the trigger (bit 15) and 8 for control (bit 0 set selects 24-hour range). Reading addresses 0 to 6 returns the live field zero-extended to 16 bits. Reading address 7 always returns 0. Reading address 8 returns the control bit.
- R3: Writes to addresses 0 to 6 change only the staged copies, and the live values read back unchanged. A write to address 7 with bit 15 clear commits nothing.
- R4: A write to address 7 with bit 15 set loads all staged fields and the leap flag into the live registers at that clock edge.
- R5: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours.
- R6: In 24-hour range the hours count 00 to 23. The roll from 23 to 00 advances the day and the weekday.
- R7: In 12-hour range the hours count 00 to 11. The day and the weekday advance only on every second roll from 11 to 00. A commit resets this half-day phase so that the next roll does not advance the day.
- R8: The weekday counts 0 to 6 and wraps from 6 to 0.
- R9: The day rolls to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 28 days, or 29 when the leap flag is set. All other months have 31 days.
- R10: The month rolls from 12 to 01 and carries into the year. The year rolls from 99 to 00.
- R11: When a commit and a tick fall in the same cycle, the committed values are loaded and the increment for that tick is lost.
- R12: In cycles with the tick low and no commit, no live field changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance, one cycle per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for addr_i |

## Verification
The range assertions assume that software commits only legal BCD values, with each field inside its range and the day inside the month it is loaded with. They also assume that the 24-hour bit does not change while the hour is above 11. The stimulus keeps to these limits: every scenario loads a complete legal date before it ticks, and it writes the control bit only right before a fresh commit. Roll-over corners are reached by committing a time one second before the boundary and then applying a single tick. The one exception is the 12-hour case, which runs the clock through a full half day.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int WDAY_W = 3;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_SEC  = 4'd0,
    A_MIN  = 4'd1,
    A_HOUR = 4'd2,
    A_WDAY = 4'd3,
    A_DAY  = 4'd4,
    A_MON  = 4'd5,
    A_YEAR = 4'd6,
    A_TRIG = 4'd7,
    A_CTRL = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [DAY_W-1:0]  day;
    logic [MON_W-1:0]  mon;
    logic [YEAR_W-1:0] year;
    logic              leap;
  } cal_t;

  // last BCD day of a BCD month
  function automatic logic [DAY_W-1:0] month_last(input logic [MON_W-1:0] mon,
                                                   input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr #(
  parameter int           W       = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q;
  logic [W-1:0] nxt;
  logic         at_top;

  generate
    if (W <= 4) begin : g_bin
      assign nxt = val_q + W'(1);
    end else begin : g_bcd
      localparam int HW = W - 4;
      logic [HW-1:0] hi_dig;
      logic [3:0]    lo_dig;
      assign hi_dig = val_q[W-1:4];
      assign lo_dig = val_q[3:0];
      assign nxt = (lo_dig >= 4'h9) ? {hi_dig + HW'(1), 4'h0} : {hi_dig, lo_dig + 4'h1};
    end
  endgenerate

  // >= so that an out-of-range load still wraps
  assign at_top = (val_q >= hi_i);
  assign wrap_o = inc_i && at_top;
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= at_top ? lo_i : nxt;
  end

  a_r11_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (val_o == $past(load_val_i)));
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_i) |=> $stable(val_o));
  a_r5_wrap_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && wrap_o) |=> (val_o == $past(lo_i)));
endmodule

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cal_t              stage_o,
  output logic              mode24_o,
  output logic              commit_o
);
  localparam int TOP = DATA_W - 1;

  cal_t stage_q;
  logic mode24_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[TOP-1:YEAR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '{sec: '0, min: '0, hour: '0, wday: '0, day: 6'h01,
                    mon: 5'h01, year: '0, leap: 1'b0};
      mode24_q <= 1'b0;
    end else if (we_i) begin
      case (addr_i)
        A_SEC:  stage_q.sec  <= wdata_i[SEC_W-1:0];
        A_MIN:  stage_q.min  <= wdata_i[MIN_W-1:0];
        A_HOUR: stage_q.hour <= wdata_i[HOUR_W-1:0];
        A_WDAY: stage_q.wday <= wdata_i[WDAY_W-1:0];
        A_DAY:  stage_q.day  <= wdata_i[DAY_W-1:0];
        A_MON:  stage_q.mon  <= wdata_i[MON_W-1:0];
        A_YEAR: begin
          stage_q.year <= wdata_i[YEAR_W-1:0];
          stage_q.leap <= wdata_i[TOP];
        end
        A_CTRL: mode24_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign stage_o  = stage_q;
  assign mode24_o = mode24_q;
  assign commit_o = we_i && (addr_i == A_TRIG) && wdata_i[TOP];
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int TOP = DATA_W - 1;

  cal_t stage;
  cal_t live;
  logic mode24, commit;
  logic tick_eff, sec_w, min_w, hour_w, day_adv, day_w, mon_w;
  logic wday_w_unused, year_w_unused;
  logic leap_q, half_q;
  logic [HOUR_W-1:0] hour_top;
  logic [DAY_W-1:0]  day_top;

  rtc_cal_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .stage_o(stage), .mode24_o(mode24), .commit_o(commit)
  );

  assign tick_eff = tick_i && !commit;  // commit discards the tick
  assign hour_top = mode24 ? 6'h23 : 6'h11;
  assign day_top  = month_last(live.mon, leap_q);
  assign day_adv  = hour_w && (mode24 || half_q);

  rtc_bcd_ctr #(.W(SEC_W), .RST_VAL(7'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick_eff), .load_i(commit), .load_val_i(stage.sec),
    .lo_i(7'h00), .hi_i(7'h59), .val_o(live.sec), .wrap_o(sec_w));
  rtc_bcd_ctr #(.W(MIN_W), .RST_VAL(7'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_w), .load_i(commit), .load_val_i(stage.min),
    .lo_i(7'h00), .hi_i(7'h59), .val_o(live.min), .wrap_o(min_w));
  rtc_bcd_ctr #(.W(HOUR_W), .RST_VAL(6'h00)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_w), .load_i(commit), .load_val_i(stage.hour),
    .lo_i(6'h00), .hi_i(hour_top), .val_o(live.hour), .wrap_o(hour_w));
  rtc_bcd_ctr #(.W(WDAY_W), .RST_VAL(3'd0)) u_wday (
    .clk_i, .rst_ni, .inc_i(day_adv), .load_i(commit), .load_val_i(stage.wday),
    .lo_i(3'd0), .hi_i(3'd6), .val_o(live.wday), .wrap_o(wday_w_unused));
  rtc_bcd_ctr #(.W(DAY_W), .RST_VAL(6'h01)) u_day (
    .clk_i, .rst_ni, .inc_i(day_adv), .load_i(commit), .load_val_i(stage.day),
    .lo_i(6'h01), .hi_i(day_top), .val_o(live.day), .wrap_o(day_w));
  rtc_bcd_ctr #(.W(MON_W), .RST_VAL(5'h01)) u_mon (
    .clk_i, .rst_ni, .inc_i(day_w), .load_i(commit), .load_val_i(stage.mon),
    .lo_i(5'h01), .hi_i(5'h12), .val_o(live.mon), .wrap_o(mon_w));
  rtc_bcd_ctr #(.W(YEAR_W), .RST_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(mon_w), .load_i(commit), .load_val_i(stage.year),
    .lo_i(8'h00), .hi_i(8'h99), .val_o(live.year), .wrap_o(year_w_unused));

  assign live.leap = leap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leap_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      if (commit) leap_q <= stage.leap;
      if (commit)      half_q <= 1'b0;
      else if (hour_w) half_q <= mode24 ? 1'b0 : !half_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SEC:  rdata_o = DATA_W'(live.sec);
      A_MIN:  rdata_o = DATA_W'(live.min);
      A_HOUR: rdata_o = DATA_W'(live.hour);
      A_WDAY: rdata_o = DATA_W'(live.wday);
      A_DAY:  rdata_o = DATA_W'(live.day);
      A_MON:  rdata_o = DATA_W'(live.mon);
      A_YEAR: begin
        rdata_o = DATA_W'(live.year);
        rdata_o[TOP] = leap_q;
      end
      A_CTRL: rdata_o = DATA_W'(mode24);
      default: rdata_o = '0;
    endcase
  end

  // legal commits assumed
  a_r6_hour_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live.hour <= 6'h23);
  a_r9_day_in_month: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live.day >= 6'h01) && (live.day <= day_top));
  a_r8_wday_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live.wday <= 3'd6);
  a_r10_new_year: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_w && !commit) |=> (live.mon == 5'h01) && (live.day == 6'h01));
  a_r7_half_day_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit && !mode24 && hour_w && !half_q) |=> $stable(live.day));
  a_r2_trig_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_TRIG) |-> (rdata_o == '0));
endmodule

// File: tb/rtc_bcd_calendar_bench.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int errs = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar u_rtc_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
    we = 1'b0; addr = a; #0.4;
    chk(req, rdata, exp);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(logic [15:0] s, m, h, w, d, mo, y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
    wr(7, 16'h8000);
  endtask

  task automatic chk_time(string req, logic [15:0] s, m, h, w, d, mo, y);
    rd_chk({req, " sec"}, 0, s);  rd_chk({req, " min"}, 1, m);
    rd_chk({req, " hour"}, 2, h); rd_chk({req, " wday"}, 3, w);
    rd_chk({req, " day"}, 4, d);  rd_chk({req, " mon"}, 5, mo);
    rd_chk({req, " year"}, 6, y);
  endtask

  task automatic t_reset();  // R1
    chk_time("R1", 16'h00, 16'h00, 16'h00, 16'h0, 16'h01, 16'h01, 16'h0000);
    rd_chk("R1 ctrl", 8, 16'h0000);
  endtask

  task automatic t_staging();  // R3
    wr(0, 16'h0033); wr(4, 16'h0022); wr(7, 16'h7FFF);
    rd_chk("R3 sec", 0, 16'h0000);
    rd_chk("R3 day", 4, 16'h0001);
  endtask

  task automatic t_commit();  // R4, R2
    set_time(16'h45, 16'h30, 16'h08, 16'h2, 16'h15, 16'h07, 16'h8024);
    chk_time("R4", 16'h45, 16'h30, 16'h08, 16'h2, 16'h15, 16'h07, 16'h8024);
    rd_chk("R2 trig", 7, 16'h0000);
    wr(8, 16'h0001);
    rd_chk("R2 ctrl", 8, 16'h0001);
  endtask

  task automatic t_sec_min();  // R5
    set_time(16'h59, 16'h12, 16'h07, 16'h1, 16'h10, 16'h03, 16'h05);
    ticks(1);
    chk_time("R5 sec", 16'h00, 16'h13, 16'h07, 16'h1, 16'h10, 16'h03, 16'h05);
    set_time(16'h59, 16'h59, 16'h13, 16'h1, 16'h10, 16'h03, 16'h05);
    ticks(1);
    chk_time("R5 min", 16'h00, 16'h00, 16'h14, 16'h1, 16'h10, 16'h03, 16'h05);
  endtask

  task automatic t_day24();  // R6
    set_time(16'h59, 16'h59, 16'h23, 16'h3, 16'h10, 16'h05, 16'h21);
    ticks(1);
    chk_time("R6", 16'h00, 16'h00, 16'h00, 16'h4, 16'h11, 16'h05, 16'h21);
  endtask

  task automatic t_wday();  // R8
    set_time(16'h59, 16'h59, 16'h23, 16'h6, 16'h19, 16'h08, 16'h30);
    ticks(1);
    chk_time("R8", 16'h00, 16'h00, 16'h00, 16'h0, 16'h20, 16'h08, 16'h30);
  endtask

  task automatic t_month_len();  // R9
    set_time(16'h59, 16'h59, 16'h23, 16'h1, 16'h30, 16'h04, 16'h11);
    ticks(1);
    chk_time("R9 apr", 16'h00, 16'h00, 16'h00, 16'h2, 16'h01, 16'h05, 16'h11);
    set_time(16'h59, 16'h59, 16'h23, 16'h1, 16'h30, 16'h01, 16'h11);
    ticks(1);
    chk_time("R9 jan", 16'h00, 16'h00, 16'h00, 16'h2, 16'h31, 16'h01, 16'h11);
    set_time(16'h59, 16'h59, 16'h23, 16'h1, 16'h31, 16'h07, 16'h11);
    ticks(1);
    chk_time("R9 jul", 16'h00, 16'h00, 16'h00, 16'h2, 16'h01, 16'h08, 16'h11);
    set_time(16'h59, 16'h59, 16'h23, 16'h1, 16'h28, 16'h02, 16'h03);
    ticks(1);
    chk_time("R9 feb", 16'h00, 16'h00, 16'h00, 16'h2, 16'h01, 16'h03, 16'h03);
    set_time(16'h59, 16'h59, 16'h23, 16'h1, 16'h28, 16'h02, 16'h8002);
    ticks(1);
    chk_time("R9 leap28", 16'h00, 16'h00, 16'h00, 16'h2, 16'h29, 16'h02, 16'h8002);
    set_time(16'h59, 16'h59, 16'h23, 16'h1, 16'h29, 16'h02, 16'h8002);
    ticks(1);
    chk_time("R9 leap29", 16'h00, 16'h00, 16'h00, 16'h2, 16'h01, 16'h03, 16'h8002);
  endtask

  task automatic t_year();  // R10
    set_time(16'h59, 16'h59, 16'h23, 16'h5, 16'h31, 16'h12, 16'h45);
    ticks(1);
    chk_time("R10 year", 16'h00, 16'h00, 16'h00, 16'h6, 16'h01, 16'h01, 16'h46);
    set_time(16'h59, 16'h59, 16'h23, 16'h5, 16'h31, 16'h12, 16'h99);
    ticks(1);
    chk_time("R10 wrap", 16'h00, 16'h00, 16'h00, 16'h6, 16'h01, 16'h01, 16'h00);
  endtask

  task automatic t_12h();  // R7
    wr(8, 16'h0000);
    set_time(16'h59, 16'h59, 16'h11, 16'h2, 16'h05, 16'h06, 16'h10);
    ticks(1);
    chk_time("R7 first", 16'h00, 16'h00, 16'h00, 16'h2, 16'h05, 16'h06, 16'h10);
    set_time(16'h59, 16'h59, 16'h11, 16'h2, 16'h05, 16'h06, 16'h10);
    ticks(1);
    chk_time("R7 phase", 16'h00, 16'h00, 16'h00, 16'h2, 16'h05, 16'h06, 16'h10);
    ticks(43200);
    chk_time("R7 second", 16'h00, 16'h00, 16'h00, 16'h3, 16'h06, 16'h06, 16'h10);
  endtask

  task automatic t_collide();  // R11
    wr(8, 16'h0001);
    set_time(16'h20, 16'h10, 16'h09, 16'h4, 16'h12, 16'h09, 16'h33);
    wr(0, 16'h0040);
    @(negedge clk); we = 1'b1; addr = 4'd7; wdata = 16'h8000; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    chk_time("R11", 16'h40, 16'h10, 16'h09, 16'h4, 16'h12, 16'h09, 16'h33);
  endtask

  task automatic t_idle();  // R12
    repeat (20) @(negedge clk);
    chk_time("R12", 16'h40, 16'h10, 16'h09, 16'h4, 16'h12, 16'h09, 16'h33);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_staging();
    t_commit();
    t_sec_min();
    t_day24();
    t_wday();
    t_month_len();
    t_year();
    t_12h();
    t_collide();
    t_idle();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end
endmodule